// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models a 64-Kbit serial EEPROM that answers as a slave on a two-wire bus with a clock line and an open-drain data line. Both lines are sampled with the system clock. Each line passes through a two-flop synchronizer and a majority filter that removes short glitches. The array holds 8192 bytes in 256 pages of 32 bytes, addressed by a 13-bit word pointer. Three strap inputs let up to eight such devices share one bus.

A master writes by sending a device-select byte, two address bytes and then one or more data bytes. The data bytes collect in a page buffer. They reach the array only when the master ends the transfer with STOP and the write-protect input is low. The commit then runs as a self-timed cycle, and while it runs the device does not answer its select byte, so the master can poll for completion. A read is either a current-address read or a random read, which is a dummy write that sets the address followed by a repeated START. The read continues byte by byte for as long as the master acknowledges.

Top module: `eeprom_2w_slave`

## Requirements
- R1: After reset the data line is released (sda_pull_o = 0), no write cycle is running, the word pointer is 0 and the device is ready for a START.
- R2: The block never drives the data line high; it only asserts sda_pull_o to pull it low. Incoming bits are sampled on the filtered rising clock edge, and sda_pull_o only ever rises while the filtered clock is low.
- R3: The select byte is, from MSB to LSB, 1,0,1,0, then the three strap bits dev_sel_i[2:0], then the direction bit (0 = write, 1 = read). The block acknowledges it (holds sda_pull_o = 1 during the ninth clock) only when the first seven bits match. On a mismatch it stays silent until the next START.
- R4: After a write select come two address bytes, high byte first. Only the low 5 bits of the high byte are used and its top 3 bits are ignored. Together the two bytes form the 13-bit word address, and each address byte is acknowledged.
- R5: Up to 32 data bytes follow the address, and each is acknowledged. The low 5 address bits step by one per byte and wrap within the 32-byte page, while the upper 8 bits stay fixed. Only the bytes that were sent change in the array.
- R6: Buffered data is written only if the transfer ends with STOP. A repeated START discards it and leaves the array unchanged.
- R7: A STOP that commits data starts an internal write cycle of WRITE_CYCLES clocks. During this cycle no select byte is acknowledged. After it ends, select bytes are acknowledged again.
- R8: When wp_i is high at the STOP, the array is not changed and no write cycle starts, so the next select byte is acknowledged.
- R9: In a random read, a write select and two address bytes are followed by a repeated START and a read select. The block then sends the addressed byte MSB first, changing the data line only after a falling clock edge.
- R10: Reads auto-increment over the whole array and wrap from 8191 to 0. A current-address read continues from the byte after the last one read. A master ACK (data line low) asks for the next byte, and a master NACK ends the read.
- R11: A START that arrives partway through a byte clears the bit count, and the transfer that follows is decoded normally.
- R12: A pulse on the clock input that lasts less than half of FILT_LEN clocks is ignored and does not shift in a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples both bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired level) |
| sda_pull_o | output | 1 | 1 = pull the data line low, 0 = release it |
| dev_sel_i | input | 3 | Strap bits compared against the select byte |
| wp_i | input | 1 | Write protect; high blocks every commit |

## Verification
The hardest state to reach from the ports is the window after a committing STOP, because the device then refuses its own select byte. The same applies to telling apart a committed page and a page discarded by a repeated START. The stimulus therefore polls the select byte at once after a STOP and again after the cycle has expired. It also ends one write with a repeated START straight into a random read of the same byte. A partial page that wraps over the top of a fully written page checks that untouched bytes survive. A one-clock dip on the clock line in the middle of a data byte checks the filter, and a select byte cut off by START checks the bit count clear.

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave #(
  parameter int ADDR_W       = 13,
  parameter int PAGE_W       = 5,
  parameter int FILT_LEN     = 3,
  parameter int WRITE_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] dev_sel_i,
  input  logic       wp_i
);
  localparam int MEM_BYTES  = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int HI_W       = ADDR_W - 8;
  localparam int PG_W       = ADDR_W - PAGE_W;
  localparam int BCW        = ($clog2(WRITE_CYCLES) > PAGE_W + 1) ? $clog2(WRITE_CYCLES) : PAGE_W + 1;
  localparam logic [ADDR_W-1:0] PTR_ONE = 1;
  localparam logic [PAGE_W-1:0] OFF_ONE = 1;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_AHI, S_AHI_ACK, S_ALO, S_ALO_ACK,
    S_WR, S_WR_ACK, S_RD, S_RD_ACK
  } st_t;

  logic [1:0]          scl_s, sda_s;
  logic [FILT_LEN-1:0] scl_w, sda_w;
  logic                scl_f, sda_f, scl_q, sda_q;
  st_t                 state;
  logic [3:0]          cnt;
  logic [7:0]          sh, osh;
  logic                rw, mack, pull, wr_pend, busy;
  logic [HI_W-1:0]     ahi;
  logic [ADDR_W-1:0]   ptr;
  logic [PG_W-1:0]     wpage;
  logic [PAGE_BYTES-1:0] mask;
  logic [BCW-1:0]      bcnt;
  logic [7:0]          pbuf [PAGE_BYTES];
  logic [7:0]          mem  [MEM_BYTES];

  function automatic logic maj(input logic [FILT_LEN-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < FILT_LEN; i++) n += int'(v[i]);
    return n > FILT_LEN / 2;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_w <= '1; sda_w <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_w <= {scl_w[FILT_LEN-2:0], scl_s[1]};
      sda_w <= {sda_w[FILT_LEN-2:0], sda_s[1]};
      scl_f <= maj(scl_w);
      sda_f <= maj(sda_w);
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_ev = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
  wire rx_state = (state == S_DEV) || (state == S_AHI) || (state == S_ALO) || (state == S_WR);
  wire byte_in  = scl_fall && rx_state && (cnt == 4'd8);
  wire [PAGE_W-1:0] bidx = bcnt[PAGE_W-1:0];
  wire mem_we   = busy && (bcnt < BCW'(PAGE_BYTES)) && mask[bidx];
  wire [7:0] rd_byte = mem[ptr];

  assign sda_pull_o = pull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; sh <= '0; osh <= '0; rw <= 1'b0; mack <= 1'b1;
      pull <= 1'b0; wr_pend <= 1'b0; busy <= 1'b0; ahi <= '0; ptr <= '0;
      wpage <= '0; mask <= '0; bcnt <= '0;
    end else begin
      if (busy) begin
        bcnt <= bcnt + 1'b1;
        if (bcnt == BCW'(WRITE_CYCLES - 1)) busy <= 1'b0;
      end
      if (start_ev) begin
        state <= S_DEV; cnt <= '0; pull <= 1'b0; wr_pend <= 1'b0;
      end else if (stop_ev) begin
        state <= S_IDLE; pull <= 1'b0; wr_pend <= 1'b0;
        if (wr_pend && !wp_i) begin
          busy <= 1'b1; bcnt <= '0;
        end
      end else if (scl_rise) begin
        if (rx_state && cnt != 4'd8) begin
          sh  <= {sh[6:0], sda_f};
          cnt <= cnt + 4'd1;
        end else if (state == S_RD_ACK) begin
          mack <= sda_f;
        end
      end else if (scl_fall) begin
        case (state)
          S_DEV: if (cnt == 4'd8) begin
            if (sh[7:1] == {4'b1010, dev_sel_i} && !busy) begin
              pull <= 1'b1; rw <= sh[0]; state <= S_DEV_ACK;
            end else state <= S_IDLE;
          end
          S_AHI: if (cnt == 4'd8) begin
            pull <= 1'b1; ahi <= sh[HI_W-1:0]; state <= S_AHI_ACK;
          end
          S_ALO: if (cnt == 4'd8) begin
            pull <= 1'b1; ptr <= {ahi, sh}; wpage <= {ahi, sh[7:PAGE_W]}; state <= S_ALO_ACK;
          end
          S_WR: if (cnt == 4'd8) begin
            pull <= 1'b1; wr_pend <= 1'b1; mask[ptr[PAGE_W-1:0]] <= 1'b1;
            ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + OFF_ONE;
            state <= S_WR_ACK;
          end
          S_DEV_ACK: begin
            cnt <= '0;
            if (rw) begin
              osh <= rd_byte; pull <= ~rd_byte[7]; state <= S_RD;
            end else begin
              pull <= 1'b0; mask <= '0; state <= S_AHI;
            end
          end
          S_AHI_ACK: begin pull <= 1'b0; cnt <= '0; state <= S_ALO; end
          S_ALO_ACK, S_WR_ACK: begin pull <= 1'b0; cnt <= '0; state <= S_WR; end
          S_RD: if (cnt == 4'd7) begin
            pull <= 1'b0; ptr <= ptr + PTR_ONE; state <= S_RD_ACK;
          end else begin
            osh <= {osh[6:0], 1'b0}; pull <= ~osh[6]; cnt <= cnt + 4'd1;
          end
          S_RD_ACK: if (!mack) begin
            osh <= rd_byte; pull <= ~rd_byte[7]; cnt <= '0; state <= S_RD;
          end else state <= S_IDLE;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (byte_in && state == S_WR) pbuf[ptr[PAGE_W-1:0]] <= sh;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[{wpage, bidx}] <= pbuf[bidx];
  end
endmodule

// File: rtl/eeprom_2w_slave_chk.sv
module eeprom_2w_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic pull,
  input logic busy,
  input logic wp,
  input logic dev_ack
);
  always @(posedge clk) begin
    if ($rose(rst_n)) assert_reset_idle_R1: assert (!pull && !busy);
  end

  assert_pull_in_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull) |-> !scl_f);

  assert_no_select_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dev_ack);

  assert_select_after_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_ack) |-> $past(!busy));

  assert_protect_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!wp));
endmodule

bind eeprom_2w_slave eeprom_2w_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .pull(sda_pull_o),
  .busy(busy), .wp(wp_i), .dev_ack(state == S_DEV_ACK)
);

// File: tb/eeprom_2w_slave_test.sv
`timescale 1ns/1ps
module eeprom_2w_slave_test;
  localparam int WC = 600;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_pull_o;
  wire  sda_bus = sda_m & ~sda_pull_o;

  int checks = 0, errors = 0;
  bit cmp_en = 0, exp_pull = 0, done = 0;
  string cur_req = "R1";

  logic [7:0] mdl [0:8191];
  int mptr = 0;
  bit mbusy = 0;

  eeprom_2w_slave #(.WRITE_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull_o), .dev_sel_i(SEL), .wp_i(wp)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if (sda_pull_o !== exp_pull) begin
        errors++;
        $display("FAIL %s: sda_pull_o=%0b expected %0b at %0t", cur_req, sda_pull_o, exp_pull, $time);
      end
    end
  end

  task automatic tk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_x(input logic m, input logic e, input bit gl);
    scl = 1'b0; cmp_en = 0; tk(6);
    sda_m = m; tk(6);
    exp_pull = e; cmp_en = 1; tk(4);
    scl = 1'b1;
    if (gl) begin tk(8); scl = 1'b0; tk(1); scl = 1'b1; tk(7); end
    else tk(16);
  endtask

  task automatic start_c();
    scl = 1'b0; cmp_en = 0; tk(16);
    sda_m = 1'b1; tk(4);
    scl = 1'b1; tk(12);
    exp_pull = 0; cmp_en = 1; sda_m = 1'b0; tk(12);
  endtask

  task automatic stop_c();
    scl = 1'b0; cmp_en = 0; tk(6);
    sda_m = 1'b0; tk(10);
    exp_pull = 0; cmp_en = 1; scl = 1'b1; tk(8);
    sda_m = 1'b1; tk(12);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit ack, input bit gl);
    for (int i = 7; i >= 0; i--) bit_x(b[i], 1'b0, gl && i == 3);
    bit_x(1'b1, ack, 0);
  endtask

  task automatic recv_byte(input logic [7:0] b, input bit more);
    for (int i = 7; i >= 0; i--) bit_x(1'b1, ~b[i], 0);
    bit_x(more ? 1'b0 : 1'b1, 1'b0, 0);
  endtask

  task automatic tx_write(input logic [2:0] dev, input logic [7:0] hi, input logic [7:0] lo,
                          input logic [7:0] d[$], input bit dostop, input bit gl, input string tag);
    bit ack;
    int base, off;
    ack = (dev == SEL) && !mbusy;
    cur_req = tag; start_c();
    send_byte({4'b1010, dev, 1'b0}, ack, 0);
    if (!ack) begin stop_c(); return; end
    cur_req = "R4"; send_byte(hi, 1, 0); send_byte(lo, 1, 0);
    base = int'(hi[4:0]) * 256 + int'(lo[7:5]) * 32;
    off  = int'(lo[4:0]);
    for (int k = 0; k < d.size(); k++) begin
      cur_req = (gl && k == 0) ? "R12" : "R5";
      send_byte(d[k], 1, gl && k == 0);
    end
    mptr = base + (off + d.size()) % 32;
    if (dostop) begin
      cur_req = "R6"; stop_c();
      if (d.size() > 0 && !wp) begin
        for (int k = 0; k < d.size(); k++) mdl[base + (off + k) % 32] = d[k];
        mbusy = 1;
      end
    end
  endtask

  task automatic rd_seq(input int n);
    cur_req = "R3"; send_byte({4'b1010, SEL, 1'b1}, 1, 0);
    for (int k = 0; k < n; k++) begin
      cur_req = (mptr == 0 && k > 0) ? "R10 wrap" : "R9";
      recv_byte(mdl[mptr], k < n - 1);
      mptr = (mptr + 1) % 8192;
    end
    cur_req = "R10"; stop_c();
  endtask

  task automatic tx_read_rand(input int addr, input int n);
    cur_req = "R9"; start_c();
    send_byte({4'b1010, SEL, 1'b0}, 1, 0);
    cur_req = "R4";
    send_byte(8'(addr >> 8), 1, 0); send_byte(8'(addr), 1, 0);
    cur_req = "R9"; start_c();
    mptr = addr;
    rd_seq(n);
  endtask

  task automatic tx_read_cur(input int n);
    cur_req = "R10"; start_c();
    rd_seq(n);
  endtask

  task automatic wait_done();
    tk(WC + 60); mbusy = 0;
  endtask

  initial begin
    logic [7:0] q[$];
    logic [7:0] none[$];
    tk(5); rst_n = 1'b1; tk(3);
    checks++;
    if (sda_pull_o !== 1'b0) begin
      errors++; $display("FAIL R1: sda_pull_o=%0b expected 0 after reset", sda_pull_o);
    end
    tx_write(SEL, 8'h00, 8'h00, none, 1, 0, "R1");

    q = '{8'h5A, 8'h6B};
    tx_write(SEL, 8'hE0, 8'h05, q, 1, 1, "R3");
    tx_write(SEL, 8'h00, 8'h00, none, 1, 0, "R7");
    wait_done();
    tx_write(SEL, 8'h00, 8'h00, none, 1, 0, "R7");
    tx_read_rand(5, 1);
    tx_read_cur(1);

    tx_write(3'b100, 8'h00, 8'h05, none, 1, 0, "R3");

    q.delete();
    for (int k = 0; k < 32; k++) q.push_back(8'(k * 3 + 1));
    tx_write(SEL, 8'h1F, 8'h20, q, 1, 0, "R3");
    wait_done();
    q.delete();
    for (int k = 0; k < 6; k++) q.push_back(8'(8'hC0 + k));
    tx_write(SEL, 8'h1F, 8'h3C, q, 1, 0, "R3");
    wait_done();
    tx_read_rand(16'h1F20, 32);

    q = '{8'h99};
    tx_write(SEL, 8'h1F, 8'hFF, q, 1, 0, "R3");
    wait_done();
    q = '{8'h11};
    tx_write(SEL, 8'h00, 8'h00, q, 1, 0, "R3");
    wait_done();
    tx_read_rand(16'h1FFF, 2);

    q = '{8'hEE};
    tx_write(SEL, 8'h00, 8'h05, q, 0, 0, "R6");
    tx_read_rand(5, 1);

    wp = 1'b1;
    q = '{8'h33};
    tx_write(SEL, 8'h00, 8'h06, q, 1, 0, "R8");
    tx_write(SEL, 8'h00, 8'h00, none, 1, 0, "R8");
    wp = 1'b0;
    tx_read_rand(6, 1);

    cur_req = "R11"; start_c();
    bit_x(1'b1, 1'b0, 0); bit_x(1'b0, 1'b0, 0); bit_x(1'b1, 1'b0, 0);
    tx_read_rand(16'h1F3C, 1);

    tk(20);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule